// File: doc/BRIEF.md
# USB Host Start-of-Frame Interrupt and Token Cancel Controller

This block sits next to the frame timer and token engine of a USB host. At each automatic start-of-frame (SOF) it decides whether to raise a sticky SOF interrupt flag. In step mode the flag is raised on every automatic SOF. Otherwise it is raised only when the low byte of the frame number sent in that SOF equals a software compare value. The flag drives the interrupt line only while a separate interrupt-enable input is high.

The block also schedules tokens that software writes into a 3-bit token field. A token written outside the end-of-frame (EOF) window launches on the next idle cycle. A token that is pending while the EOF window is open is held until the next automatic SOF. At that SOF the held token is either launched right after the SOF, or cancelled. A cancelled token clears the token field and sets a sticky token-cancel flag. Software must clear that flag before it can write a new token. A software-issued SOF token launches like any other token but never sets the SOF flag.

Top module: `usb_sof_irq_ctrl`

## Requirements
- R1: After reset the SOF flag, the cancel flag, the token field, the launch strobe and the interrupt line are all 0.
- R2: When step mode is 1, every automatic SOF strobe sets the SOF flag, and the flag is visible in the cycle after the strobe.
- R3: When step mode is 0, an automatic SOF sets the SOF flag only if frame number bits [7:0] equal the 8-bit compare value. Frame bits [10:8] take no part in the match.
- R4: The interrupt line is high exactly when the SOF flag is set and the SOF interrupt enable is 1.
- R5: Both flags are sticky. Each is cleared, from the next cycle on, only by its own clear strobe. A set and a clear in the same cycle leave the flag set.
- R6: Token codes are 000 = idle, 001 = software SOF token, 010..111 = other tokens. A nonzero code written outside the EOF window, while the field is idle and the cancel flag is clear, shows in the field in the next cycle. One cycle later the launch strobe is high for exactly one cycle and the field returns to 000. Launching code 001 does not set the SOF flag.
- R7: A token that is pending while the EOF window input is high is held. It does not launch until the next automatic SOF strobe.
- R8: A held token with code 010..111 is cancelled at an SOF that sets the SOF flag while the cancel enable is 1. In the cycle after that SOF the field is 000, the cancel flag is 1, and no launch strobe is given.
- R9: In every other case a held token is launched at the next SOF, and the launch strobe is high in the cycle after the SOF strobe. These cases are: the cancel enable is 0, the SOF does not qualify for the flag, or the code is 001.
- R10: A token write is ignored while the cancel flag is set or while the token field is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sof_start_i | input | 1 | Automatic SOF start strobe from the frame timer |
| eof_window_i | input | 1 | High while the end-of-frame window is open |
| frame_num_i | input | 11 | Frame number sent in the current SOF |
| frame_cmp_i | input | 8 | Compare value for the frame number low byte |
| step_mode_i | input | 1 | 1: flag on every SOF; 0: flag on low-byte match only |
| sof_irq_en_i | input | 1 | SOF interrupt enable |
| cancel_en_i | input | 1 | Cancel held tokens at a qualifying SOF |
| tok_wr_i | input | 1 | Token field write strobe |
| tok_wdata_i | input | 3 | Token code to write |
| sof_clr_i | input | 1 | Clear strobe for the SOF flag (write one to clear) |
| tcan_clr_i | input | 1 | Clear strobe for the token-cancel flag (write one to clear) |
| sof_flag_o | output | 1 | Sticky SOF interrupt flag |
| tcan_flag_o | output | 1 | Sticky token-cancel flag |
| tok_launch_o | output | 1 | One-cycle strobe that starts the token engine |
| tok_en_o | output | 3 | Current token field |
| irq_o | output | 1 | Interrupt line |

## Verification
A hold bit that is wrongly clear shows up as a launch strobe two cycles after a token is written inside the EOF window, long before any SOF. A hold bit that is wrongly set shows up as a token field that stays nonzero after an idle cycle. A bad frame-match decision appears on the SOF flag and the interrupt line in the cycle after the SOF strobe. A cancel decision that goes the wrong way appears one cycle after that SOF. The cancel flag, the launch strobe and the token field then disagree with each other. Because both flags are sticky, a lost set or a stray clear stays visible at the ports until software clears the flag.

// File: rtl/usb_sof_pkg.sv
package usb_sof_pkg;
  localparam int TOK_W   = 3;
  localparam int FRAME_W = 11;
  localparam int CMP_W   = 8;

  localparam logic [TOK_W-1:0] TOK_IDLE = '0;
  localparam logic [TOK_W-1:0] TOK_SOF  = TOK_W'(1);

  // Only real transfer tokens may be dropped at an SOF.
  function automatic logic tok_cancellable(input logic [TOK_W-1:0] code);
    return (code != TOK_IDLE) && (code != TOK_SOF);
  endfunction

  // Low-byte frame match used when step mode is off.
  function automatic logic frame_low_match(input logic [FRAME_W-1:0] frame,
                                           input logic [CMP_W-1:0]   cmp);
    return frame[CMP_W-1:0] == cmp;
  endfunction
endpackage

// File: rtl/sof_qualifier.sv
module sof_qualifier
  import usb_sof_pkg::*;
#(
  parameter int FW = FRAME_W,
  parameter int CW = CMP_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sof_start_i,
  input  logic          step_mode_i,
  input  logic [FW-1:0] frame_i,
  input  logic [CW-1:0] cmp_i,
  output logic          sof_hit_o
);
  logic match;
  assign match     = frame_low_match(frame_i, cmp_i);
  assign sof_hit_o = sof_start_i & (step_mode_i | match);

  // R2: step mode qualifies every automatic SOF
  a_r2_step_every_sof: assert property (@(posedge clk) disable iff (!rst_n)
    (sof_start_i && step_mode_i) |-> sof_hit_o);
  // no SOF strobe means no qualifying event
  a_r2_hit_needs_sof: assert property (@(posedge clk) disable iff (!rst_n)
    !sof_start_i |-> !sof_hit_o);
endmodule

// File: rtl/sticky_flag.sv
module sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end
  assign flag_o = flag_q;

  // R5: set wins and is visible next cycle
  a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);
  // R5: flag holds without a clear
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !clr_i) |=> flag_o);
  // R5: a lone clear drops the flag
  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/token_sched.sv
module token_sched
  import usb_sof_pkg::*;
#(
  parameter int TW = TOK_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          eof_window_i,
  input  logic          sof_start_i,
  input  logic          sof_hit_i,
  input  logic          cancel_en_i,
  input  logic          tcan_i,
  input  logic          tok_wr_i,
  input  logic [TW-1:0] tok_wdata_i,
  output logic [TW-1:0] tok_en_o,
  output logic          tok_launch_o,
  output logic          cancel_evt_o
);
  logic [TW-1:0] tok_en_q;
  logic          held_q;
  logic          launch_q;
  logic          pending, accept_wr, resolve, cancel_evt, launch_now;

  assign pending    = tok_en_q != '0;
  assign accept_wr  = tok_wr_i & ~pending & ~tcan_i & (tok_wdata_i != '0);
  assign resolve    = held_q & sof_start_i;
  assign cancel_evt = resolve & cancel_en_i & sof_hit_i & tok_cancellable(tok_en_q);
  assign launch_now = pending & ((resolve & ~cancel_evt) | (~held_q & ~eof_window_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tok_en_q <= '0;
      held_q   <= 1'b0;
      launch_q <= 1'b0;
    end else begin
      launch_q <= launch_now;
      if (cancel_evt || launch_now) begin
        tok_en_q <= '0;
        held_q   <= 1'b0;
      end else if (accept_wr) begin
        tok_en_q <= tok_wdata_i;
        held_q   <= eof_window_i;
      end else if (pending && eof_window_i) begin
        held_q   <= 1'b1;
      end
    end
  end

  assign tok_en_o     = tok_en_q;
  assign tok_launch_o = launch_q;
  assign cancel_evt_o = cancel_evt;

  // R8: a cancelled token is dropped without a launch
  a_r8_cancel_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_evt |=> (!tok_launch_o && tok_en_o == '0));
  // R7: a held token waits for an SOF
  a_r7_held_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q && !sof_start_i) |=> !tok_launch_o);
  // R6: launch strobe lasts a single cycle
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tok_launch_o |=> !tok_launch_o);
  // R10: a busy field ignores new writes
  a_r10_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !launch_now && !cancel_evt && tok_wr_i) |=> tok_en_o == $past(tok_en_o));
endmodule

// File: rtl/usb_sof_irq_ctrl.sv
module usb_sof_irq_ctrl
  import usb_sof_pkg::*;
#(
  parameter int FW = FRAME_W,
  parameter int CW = CMP_W,
  parameter int TW = TOK_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sof_start_i,
  input  logic          eof_window_i,
  input  logic [FW-1:0] frame_num_i,
  input  logic [CW-1:0] frame_cmp_i,
  input  logic          step_mode_i,
  input  logic          sof_irq_en_i,
  input  logic          cancel_en_i,
  input  logic          tok_wr_i,
  input  logic [TW-1:0] tok_wdata_i,
  input  logic          sof_clr_i,
  input  logic          tcan_clr_i,
  output logic          sof_flag_o,
  output logic          tcan_flag_o,
  output logic          tok_launch_o,
  output logic [TW-1:0] tok_en_o,
  output logic          irq_o
);
  logic sof_hit;
  logic cancel_evt;

  sof_qualifier #(.FW(FW), .CW(CW)) i_qual (
    .clk(clk), .rst_n(rst_n), .sof_start_i(sof_start_i),
    .step_mode_i(step_mode_i), .frame_i(frame_num_i), .cmp_i(frame_cmp_i),
    .sof_hit_o(sof_hit)
  );

  sticky_flag i_sof_flag (
    .clk(clk), .rst_n(rst_n), .set_i(sof_hit), .clr_i(sof_clr_i), .flag_o(sof_flag_o)
  );

  sticky_flag i_tcan_flag (
    .clk(clk), .rst_n(rst_n), .set_i(cancel_evt), .clr_i(tcan_clr_i), .flag_o(tcan_flag_o)
  );

  token_sched #(.TW(TW)) i_tok (
    .clk(clk), .rst_n(rst_n), .eof_window_i(eof_window_i), .sof_start_i(sof_start_i),
    .sof_hit_i(sof_hit), .cancel_en_i(cancel_en_i), .tcan_i(tcan_flag_o),
    .tok_wr_i(tok_wr_i), .tok_wdata_i(tok_wdata_i), .tok_en_o(tok_en_o),
    .tok_launch_o(tok_launch_o), .cancel_evt_o(cancel_evt)
  );

  assign irq_o = sof_flag_o & sof_irq_en_i;

  // R3: a mismatching SOF in compare mode leaves a clear flag clear
  a_r3_mismatch_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    (sof_start_i && !step_mode_i && frame_num_i[CW-1:0] != frame_cmp_i && !sof_flag_o && !tok_wr_i)
    |=> !sof_flag_o);
  // R8: a cancellation always raises the cancel flag
  a_r8_cancel_flags: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_evt |=> (tcan_flag_o && sof_flag_o));
  // R4: no interrupt while disabled
  a_r4_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !sof_irq_en_i |-> !irq_o);
endmodule

// File: tb/test_usb_sof_irq_ctrl.sv
module test_usb_sof_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sof_start_i = 0, eof_window_i = 0, step_mode_i = 0, sof_irq_en_i = 0;
  logic       cancel_en_i = 0, tok_wr_i = 0, sof_clr_i = 0, tcan_clr_i = 0;
  logic [10:0] frame_num_i = '0;
  logic [7:0]  frame_cmp_i = '0;
  logic [2:0]  tok_wdata_i = '0;
  logic       sof_flag_o, tcan_flag_o, tok_launch_o, irq_o;
  logic [2:0] tok_en_o;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  usb_sof_irq_ctrl i_usb_sof_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .sof_start_i(sof_start_i), .eof_window_i(eof_window_i),
    .frame_num_i(frame_num_i), .frame_cmp_i(frame_cmp_i), .step_mode_i(step_mode_i),
    .sof_irq_en_i(sof_irq_en_i), .cancel_en_i(cancel_en_i), .tok_wr_i(tok_wr_i),
    .tok_wdata_i(tok_wdata_i), .sof_clr_i(sof_clr_i), .tcan_clr_i(tcan_clr_i),
    .sof_flag_o(sof_flag_o), .tcan_flag_o(tcan_flag_o), .tok_launch_o(tok_launch_o),
    .tok_en_o(tok_en_o), .irq_o(irq_o)
  );

  // {step, frame[10:0], cmp[7:0], expected flag}
  localparam logic [20:0] VEC [8] = '{
    {1'b1, 11'h005, 8'h00, 1'b1},
    {1'b0, 11'h005, 8'h05, 1'b1},
    {1'b0, 11'h005, 8'h06, 1'b0},
    {1'b0, 11'h7FF, 8'hFF, 1'b1},
    {1'b0, 11'h1A3, 8'hA3, 1'b1},
    {1'b0, 11'h2A3, 8'h23, 1'b0},
    {1'b1, 11'h2A3, 8'h23, 1'b1},
    {1'b0, 11'h000, 8'h00, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic sof(input logic step, input logic [10:0] fr, input logic [7:0] cmp);
    step_mode_i = step; frame_num_i = fr; frame_cmp_i = cmp;
    sof_start_i = 1'b1; eof_window_i = 1'b0;
    tick();
    sof_start_i = 1'b0;
  endtask

  task automatic clr_sof();
    sof_clr_i = 1'b1; tick(); sof_clr_i = 1'b0;
  endtask

  task automatic clr_tcan();
    tcan_clr_i = 1'b1; tick(); tcan_clr_i = 1'b0;
  endtask

  task automatic wr(input logic [2:0] code);
    tok_wr_i = 1'b1; tok_wdata_i = code; tick(); tok_wr_i = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    chk("R1 sof flag", sof_flag_o, 0);
    chk("R1 tcan flag", tcan_flag_o, 0);
    chk("R1 token field", tok_en_o, 0);
    chk("R1 launch", tok_launch_o, 0);
    chk("R1 irq", irq_o, 0);
    rst_n = 1'b1;
    tick();

    // R2 R3 R4: table walk
    for (int i = 0; i < 8; i++) begin
      clr_sof();
      sof_irq_en_i = i[0];
      sof(VEC[i][20], VEC[i][19:9], VEC[i][8:1]);
      chk(VEC[i][20] ? "R2 step flag" : "R3 compare flag", sof_flag_o, VEC[i][0]);
      chk("R4 irq", irq_o, VEC[i][0] & i[0]);
    end
    sof_irq_en_i = 1'b0;

    // R5 sticky behaviour
    clr_sof();
    sof(1'b1, 11'h010, 8'h00);
    tick();
    chk("R5 sticky hold", sof_flag_o, 1);
    clr_sof();
    chk("R5 clear", sof_flag_o, 0);
    sof_clr_i = 1'b1; sof(1'b1, 11'h011, 8'h00); sof_clr_i = 1'b0;
    chk("R5 set wins over clear", sof_flag_o, 1);
    clr_sof();

    // R6 plain token outside window
    wr(3'b010);
    chk("R6 field loaded", tok_en_o, 3'b010);
    chk("R6 no early launch", tok_launch_o, 0);
    tick();
    chk("R6 launch strobe", tok_launch_o, 1);
    chk("R6 field idle after launch", tok_en_o, 0);
    tick();
    chk("R6 single pulse", tok_launch_o, 0);

    // R6 software SOF token does not set SOF flag
    wr(3'b001);
    tick();
    chk("R6 sof token launch", tok_launch_o, 1);
    chk("R6 sof token no flag", sof_flag_o, 0);
    tick();

    // R7 R8 held token cancelled
    cancel_en_i = 1'b1;
    eof_window_i = 1'b1;
    wr(3'b011);
    chk("R7 held field", tok_en_o, 3'b011);
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R7 held no launch", tok_launch_o, 0);
    end
    sof(1'b1, 11'h020, 8'h00);
    chk("R8 cancel field", tok_en_o, 0);
    chk("R8 cancel flag", tcan_flag_o, 1);
    chk("R8 no launch", tok_launch_o, 0);
    tick();
    chk("R8 no late launch", tok_launch_o, 0);

    // R10 write blocked while cancel flag set
    wr(3'b100);
    chk("R10 write ignored with tcan", tok_en_o, 0);
    tick();
    chk("R10 no launch with tcan", tok_launch_o, 0);
    clr_tcan();
    chk("R5 tcan clear", tcan_flag_o, 0);
    clr_sof();

    // R9 cancel disabled: launch after SOF
    cancel_en_i = 1'b0;
    eof_window_i = 1'b1;
    wr(3'b100);
    tick();
    sof(1'b1, 11'h021, 8'h00);
    chk("R9 launch cancel off", tok_launch_o, 1);
    chk("R9 field idle", tok_en_o, 0);
    chk("R9 tcan stays clear", tcan_flag_o, 0);
    clr_sof();

    // R9 non-qualifying SOF with cancel on
    cancel_en_i = 1'b1;
    eof_window_i = 1'b1;
    wr(3'b101);
    sof(1'b0, 11'h010, 8'h20);
    chk("R9 launch on mismatch SOF", tok_launch_o, 1);
    chk("R9 no tcan on mismatch", tcan_flag_o, 0);
    chk("R3 mismatch no flag", sof_flag_o, 0);

    // R9 held SOF token is never cancelled
    eof_window_i = 1'b1;
    wr(3'b001);
    sof(1'b1, 11'h022, 8'h00);
    chk("R9 sof token launched", tok_launch_o, 1);
    chk("R9 sof token no tcan", tcan_flag_o, 0);
    clr_sof();

    // R10 busy field ignores a second write
    cancel_en_i = 1'b0;
    eof_window_i = 1'b1;
    wr(3'b010);
    wr(3'b110);
    chk("R10 busy write ignored", tok_en_o, 3'b010);
    sof(1'b1, 11'h023, 8'h00);
    chk("R10 original token launched", tok_launch_o, 1);
    tick();
    chk("R10 field idle", tok_en_o, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule